// File: doc/BRIEF.md
# Parallel ADC Host Interface Controller

This block sits on the host side of a successive-approximation converter that has an eight-input channel sequencer and a 12-bit parallel data bus. It accepts one command at a time from a request/ready handshake. A command either starts a conversion and reads back the result, or writes a 12-bit control word into the converter. All bus strobes are active low. A conversion is started with a low pulse on the start strobe. The controller then follows the converter's busy flag through its rise and its fall. After that it reads the result with chip-select and read.

The bus works in word mode or in byte mode, and the mode is chosen per command. In word mode one strobe moves the whole 12-bit field. In byte mode two strobes move it, low byte first. The high byte carries the top four data bits and the 3-bit channel ID. Each read ends in a one-cycle valid pulse. The pulse comes with the data word, the channel ID and a value that is zero-extended or sign-extended according to the coding flag. A parameter picks a 12-bit or a 10-bit converter. Spacing between accesses and the quiet time before the next start are counted in clock cycles, derived from the clock period parameter. If the converter never finishes, a watchdog gives up and flags an error.

Top module: `adc_par_host`

## Requirements
- R1: While reset is high and in the first cycle after it, adc_cs_n, adc_rd_n, adc_wr_n and adc_convst_n are all 1, adc_bus_oe is 0, res_valid is 0 and cmd_ready is 1. A reset during a conversion also returns the controller to this state.
- R2: cmd_ready is 1 only when the controller is idle. A command is taken in a cycle where cmd_valid and cmd_ready are both 1. cmd_ready is 0 in the following cycle and stays 0 until the command has completed.
- R3: A conversion command drives adc_convst_n low for exactly CNV_CYC cycles. The controller then waits for adc_busy to rise and then to fall, and only after that does it begin the read.
- R4: Each bus access holds adc_cs_n low for exactly STB_CYC cycles, with adc_rd_n low for a read or adc_wr_n low for a write, and the two are never low together. A word-mode read uses one strobe. A byte-mode read uses two: adc_hben is 0 on the first strobe and 1 on the second.
- R5: In word mode, res_data is the bus field bits 11 down to 12-DATA_W, and res_chan is 0.
- R6: In byte mode, the low-byte strobe supplies field bits 7..0 from bus bits 7..0. The high-byte strobe supplies field bits 11..8 from bus bits 3..0, and res_chan from bus bits 6..4.
- R7: With DATA_W = 10, the data LSB is field bit 2, so res_data equals field bits 11..2, and field bits 1..0 are ignored.
- R8: res_value is DATA_W+1 bits wide. It is res_data zero-extended when the coding flag (cfg_twos) was 0 at command acceptance, and sign-extended when it was 1.
- R9: res_valid is a single-cycle pulse. It is raised in the first cycle after the final read strobe of the command, with adc_cs_n already high.
- R10: A write command keeps adc_rd_n high, raises no res_valid, and drives adc_bus_oe during its strobes. In word mode it presents the whole word on the bus. In byte mode it presents the low byte on bus bits 7..0 with adc_hben 0, then the top four bits on bus bits 3..0 with adc_hben 1 and bus bits 7..4 at 0.
- R11: adc_cs_n stays high for at least GAP_CYC = ceil(GAP_NS/CLK_NS) cycles between accesses. At least QUIET_CYC = ceil(QUIET_NS/CLK_NS) cycles pass from adc_cs_n rising after a read to the next falling edge of adc_convst_n.
- R12: If adc_busy has not both risen and fallen within TIMEOUT_CYC cycles after the start pulse, conv_err pulses for one cycle. No read is made, no res_valid is raised, and the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_write | input | 1 | 1: register write, 0: convert and read |
| cmd_wdata | input | 12 | Control word for a write command |
| cfg_byte_mode | input | 1 | 1: byte transfers, 0: word transfers (sampled at acceptance) |
| cfg_twos | input | 1 | Result coding flag (sampled at acceptance) |
| adc_busy | input | 1 | Converter busy flag |
| adc_convst_n | output | 1 | Start strobe, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_hben | output | 1 | High byte enable in byte mode |
| adc_bus_in | input | 12 | Data bus from converter |
| adc_bus_out | output | 12 | Data bus to converter |
| adc_bus_oe | output | 1 | Host drives the bus |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | DATA_W | Conversion data |
| res_chan | output | 3 | Channel ID of the result |
| res_value | output | DATA_W+1 | Coded value, zero- or sign-extended |
| conv_err | output | 1 | Conversion timeout pulse |

## Verification
The result-valid pulse and the acceptance of the next command can fall in the same cycle, because the controller is idle in the very cycle it reports a result. The bench provokes this by raising cmd_valid for a new conversion exactly in the cycle where res_valid is seen. It then judges two things: that cmd_ready was high in that cycle, and that the following start strobe still keeps the full quiet time after the read's chip-select release. It also checks that the second result carries the second word and channel, not the first.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int BUS_W  = 12;
    localparam int LANE_W = 8;
    localparam int NIB_W  = 4;
    localparam int CHAN_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_CNV,
        ST_CNV_LO,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_GAP,
        ST_STB
    } seq_state_e;

    typedef enum logic {
        OP_READ,
        OP_WRITE
    } op_e;

    typedef struct packed {
        logic byte_mode;
        logic twos;
    } xfer_cfg_t;

    function automatic int ceil_cycles(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Rebuild the 12-bit field from one word beat or from two byte beats.
    function automatic logic [BUS_W-1:0] join_field(logic byte_mode,
                                                    logic [LANE_W-1:0] lo,
                                                    logic [BUS_W-1:0] bus);
        if (byte_mode)
            return {{(BUS_W-NIB_W-LANE_W){1'b0}}, bus[NIB_W-1:0], lo};
        return bus;
    endfunction

    // Lane placement of a write word for the current beat.
    function automatic logic [BUS_W-1:0] lane_word(logic byte_mode, logic hi,
                                                   logic [BUS_W-1:0] w);
        if (!byte_mode)
            return w;
        if (hi)
            return {{(BUS_W-NIB_W){1'b0}}, w[BUS_W-1 -: NIB_W]};
        return {{(BUS_W-LANE_W){1'b0}}, w[LANE_W-1:0]};
    endfunction

    function automatic logic [CHAN_W-1:0] chan_of(logic [BUS_W-1:0] bus);
        return bus[NIB_W +: CHAN_W];
    endfunction

endpackage

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
    parameter int LIMIT = 3,
    parameter int TW    = $clog2(LIMIT + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_busy,
    output logic [TW-1:0] idle_cnt
);
    localparam logic [TW-1:0] SAT = TW'(LIMIT);

    // Counts idle cycles since the last access, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (rst)
            idle_cnt <= SAT;
        else if (bus_busy)
            idle_cnt <= '0;
        else if (idle_cnt < SAT)
            idle_cnt <= idle_cnt + 1'b1;
    end

endmodule

// File: rtl/adc_conv_watch.sv
module adc_conv_watch #(
    parameter int LIMIT = 64,
    parameter int TW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic expired
);
    logic [TW-1:0] cnt;

    assign expired = arm && (cnt == TW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !arm)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    // R12: the sequencer leaves the wait on expiry, so it never lasts two cycles
    p_expire_once_r12: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired);

endmodule

// File: rtl/adc_result_unpack.sv
module adc_result_unpack
    import adc_host_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  xfer_cfg_t         cfg,
    input  logic [LANE_W-1:0] lo_byte,
    input  logic [BUS_W-1:0]  bus_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [CHAN_W-1:0] res_chan,
    output logic [DATA_W:0]   res_value
);
    logic [BUS_W-1:0]  field;
    logic [DATA_W-1:0] data_c;
    logic [CHAN_W-1:0] chan_c;
    logic [DATA_W:0]   value_c;

    always_comb begin
        field   = join_field(cfg.byte_mode, lo_byte, bus_in);
        data_c  = field[BUS_W-1 -: DATA_W];
        chan_c  = cfg.byte_mode ? chan_of(bus_in) : '0;
        value_c = {cfg.twos & data_c[DATA_W-1], data_c};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_chan  <= '0;
            res_value <= '0;
        end else begin
            res_valid <= capture;
            if (capture) begin
                res_data  <= data_c;
                res_chan  <= chan_c;
                res_value <= value_c;
            end
        end
    end

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

endmodule

// File: rtl/adc_par_host.sv
module adc_par_host
    import adc_host_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CLK_NS      = 10,
    parameter int QUIET_NS    = 30,
    parameter int GAP_NS      = 10,
    parameter int CNV_CYC     = 2,
    parameter int STB_CYC     = 2,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [11:0]       cmd_wdata,
    input  logic              cfg_byte_mode,
    input  logic              cfg_twos,
    input  logic              adc_busy,
    output logic              adc_convst_n,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              adc_wr_n,
    output logic              adc_hben,
    input  logic [11:0]       adc_bus_in,
    output logic [11:0]       adc_bus_out,
    output logic              adc_bus_oe,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [2:0]        res_chan,
    output logic [DATA_W:0]   res_value,
    output logic              conv_err
);
    localparam int QUIET_CYC = ceil_cycles(QUIET_NS, CLK_NS);
    localparam int GAP_CYC   = ceil_cycles(GAP_NS, CLK_NS);
    localparam int SPACE_MAX = max2(QUIET_CYC, GAP_CYC);
    localparam int TW        = $clog2(SPACE_MAX + 2);
    localparam int CW        = $clog2(max2(CNV_CYC, STB_CYC) + 1);
    localparam logic [TW-1:0] QUIET_LIM = TW'(QUIET_CYC);
    localparam logic [TW-1:0] GAP_LIM   = TW'(GAP_CYC);
    localparam logic [CW-1:0] CNV_LAST  = CW'(CNV_CYC - 1);
    localparam logic [CW-1:0] STB_LAST  = CW'(STB_CYC - 1);

    seq_state_e        st_q, st_d;
    op_e               op_q, op_d;
    xfer_cfg_t         cfg_q, cfg_d;
    logic              hi_q, hi_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [LANE_W-1:0] lo_q, lo_d;
    logic [BUS_W-1:0]  wd_q, wd_d;
    logic              err_q;
    logic              capture;
    logic              expired;
    logic              waiting;
    logic              on_bus;
    logic [TW-1:0]     idle_cnt;

    assign waiting = (st_q == ST_WAIT_HI) || (st_q == ST_WAIT_LO);
    assign on_bus  = (st_q == ST_STB);

    adc_gap_timer #(.LIMIT(SPACE_MAX), .TW(TW)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .bus_busy (on_bus),
        .idle_cnt (idle_cnt)
    );

    adc_conv_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .arm     (waiting),
        .expired (expired)
    );

    adc_result_unpack #(.DATA_W(DATA_W)) u_unpack (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .cfg       (cfg_q),
        .lo_byte   (lo_q),
        .bus_in    (adc_bus_in),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_chan  (res_chan),
        .res_value (res_value)
    );

    always_comb begin
        st_d    = st_q;
        op_d    = op_q;
        cfg_d   = cfg_q;
        hi_d    = hi_q;
        cnt_d   = cnt_q;
        lo_d    = lo_q;
        wd_d    = wd_q;
        capture = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    cfg_d = '{byte_mode: cfg_byte_mode, twos: cfg_twos};
                    wd_d  = cmd_wdata;
                    hi_d  = 1'b0;
                    cnt_d = '0;
                    if (cmd_write) begin
                        op_d = OP_WRITE;
                        st_d = ST_GAP;
                    end else begin
                        op_d = OP_READ;
                        st_d = ST_PRE_CNV;
                    end
                end
            end
            ST_PRE_CNV: begin
                if (idle_cnt >= QUIET_LIM) begin
                    st_d  = ST_CNV_LO;
                    cnt_d = '0;
                end
            end
            ST_CNV_LO: begin
                if (cnt_q == CNV_LAST) st_d = ST_WAIT_HI;
                else                   cnt_d = cnt_q + 1'b1;
            end
            ST_WAIT_HI: begin
                if (expired)       st_d = ST_IDLE;
                else if (adc_busy) st_d = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                if (expired) begin
                    st_d = ST_IDLE;
                end else if (!adc_busy) begin
                    st_d = ST_GAP;
                    hi_d = 1'b0;
                end
            end
            ST_GAP: begin
                if (idle_cnt >= GAP_LIM) begin
                    st_d  = ST_STB;
                    cnt_d = '0;
                end
            end
            ST_STB: begin
                if (cnt_q != STB_LAST) begin
                    cnt_d = cnt_q + 1'b1;
                end else begin
                    if (op_q == OP_READ && !hi_q)
                        lo_d = adc_bus_in[LANE_W-1:0];
                    if (cfg_q.byte_mode && !hi_q) begin
                        hi_d = 1'b1;
                        st_d = ST_GAP;
                    end else begin
                        st_d    = ST_IDLE;
                        capture = (op_q == OP_READ);
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            op_q  <= OP_READ;
            cfg_q <= '0;
            hi_q  <= 1'b0;
            cnt_q <= '0;
            lo_q  <= '0;
            wd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            op_q  <= op_d;
            cfg_q <= cfg_d;
            hi_q  <= hi_d;
            cnt_q <= cnt_d;
            lo_q  <= lo_d;
            wd_q  <= wd_d;
            err_q <= expired;
        end
    end

    assign cmd_ready    = (st_q == ST_IDLE);
    assign conv_err     = err_q;
    assign adc_convst_n = !(st_q == ST_CNV_LO);
    assign adc_cs_n     = !on_bus;
    assign adc_rd_n     = !(on_bus && op_q == OP_READ);
    assign adc_wr_n     = !(on_bus && op_q == OP_WRITE);
    assign adc_hben     = cfg_q.byte_mode && hi_q && (on_bus || st_q == ST_GAP);
    assign adc_bus_oe   = (op_q == OP_WRITE) && (on_bus || st_q == ST_GAP);
    assign adc_bus_out  = adc_bus_oe ? lane_word(cfg_q.byte_mode, hi_q, wd_q) : '0;

    p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!adc_rd_n && !adc_wr_n));

    p_strobe_cs_r4: assert property (@(posedge clk) disable iff (rst)
        (!adc_rd_n || !adc_wr_n) |-> !adc_cs_n);

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_start_off_bus_r3: assert property (@(posedge clk) disable iff (rst)
        !adc_convst_n |-> adc_cs_n);

    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (adc_convst_n && st_d == ST_CNV_LO) |-> (idle_cnt >= QUIET_LIM));

    p_hi_lanes_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (!adc_wr_n && adc_hben) |-> (adc_bus_out[7:4] == 4'h0));

    p_err_no_result_r12: assert property (@(posedge clk) disable iff (rst)
        conv_err |-> !res_valid);

endmodule

// File: tb/adc_par_host_bench.sv
module adc_par_host_bench;
    localparam int QUIET_CYC = 3;
    localparam int GAP_CYC   = 1;
    localparam int CNV_CYC   = 2;
    localparam int STB_CYC   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        cmd_valid = 0, cmd_write = 0, cfg_byte_mode = 0, cfg_twos = 0;
    logic [11:0] cmd_wdata = '0;
    logic        cmd_ready, adc_convst_n, adc_cs_n, adc_rd_n, adc_wr_n, adc_hben;
    logic        adc_bus_oe, res_valid, conv_err;
    logic [11:0] adc_bus_in, adc_bus_out;
    logic [11:0] res_data;
    logic [2:0]  res_chan;
    logic [12:0] res_value;
    logic        busy;

    logic        w_ready, w_cv, w_cs, w_rd, w_wr, w_hb, w_oe, w_valid, w_err;
    logic [11:0] w_bus;
    logic [9:0]  w_data;
    logic [2:0]  w_chan;
    logic [10:0] w_value;

    adc_par_host u_adc_par_host (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cfg_byte_mode(cfg_byte_mode),
        .cfg_twos(cfg_twos), .adc_busy(busy), .adc_convst_n(adc_convst_n),
        .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_wr_n(adc_wr_n),
        .adc_hben(adc_hben), .adc_bus_in(adc_bus_in), .adc_bus_out(adc_bus_out),
        .adc_bus_oe(adc_bus_oe), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .res_value(res_value), .conv_err(conv_err));

    adc_par_host #(.DATA_W(10)) u_adc_par_host_w10 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(w_ready),
        .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cfg_byte_mode(cfg_byte_mode),
        .cfg_twos(cfg_twos), .adc_busy(busy), .adc_convst_n(w_cv),
        .adc_cs_n(w_cs), .adc_rd_n(w_rd), .adc_wr_n(w_wr),
        .adc_hben(w_hb), .adc_bus_in(adc_bus_in), .adc_bus_out(w_bus),
        .adc_bus_oe(w_oe), .res_valid(w_valid), .res_data(w_data),
        .res_chan(w_chan), .res_value(w_value), .conv_err(w_err));

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Converter responder
    logic        hang = 0, tb_byte = 0, cv_q;
    logic [11:0] rsp_data = '0;
    logic [2:0]  rsp_chan = '0;
    int          conv_len = 12, busy_cnt;

    always @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; busy_cnt <= 0; cv_q <= 1'b1;
        end else begin
            cv_q <= adc_convst_n;
            if (cv_q && !adc_convst_n) begin
                busy <= 1'b1; busy_cnt <= conv_len;
            end else if (busy && !hang) begin
                if (busy_cnt == 0) busy <= 1'b0;
                else busy_cnt <= busy_cnt - 1;
            end
        end
    end

    assign adc_bus_in = (!adc_cs_n && !adc_rd_n) ?
        (tb_byte ? (adc_hben ? {5'b0, rsp_chan, rsp_data[11:8]} : {4'b0, rsp_data[7:0]})
                 : rsp_data) : 12'h000;

    // Bus monitor, sampled away from the active edge
    logic        p_cs = 1, p_cv = 1, p_rd = 1;
    int          gap_cnt = 100, q_cnt = 100, cs_len = 0, cv_len = 0;
    int          rd_cnt = 0, wr_cnt = 0, val_cnt = 0;
    logic        hb_prev = 0, hb_last = 0;
    logic [13:0] wl_prev = '0, wl_last = '0;

    always @(negedge clk) begin
        if (rst) begin
            p_cs = 1; p_cv = 1; p_rd = 1; cs_len = 0; cv_len = 0;
        end else begin
            if (res_valid) val_cnt++;
            if (!adc_rd_n && !adc_wr_n) chk(0, "R4 read and write strobes overlap", 0, 1);
            if (!adc_cs_n && p_cs) begin
                chk(gap_cnt >= GAP_CYC, "R11 gap between accesses", gap_cnt, GAP_CYC);
                if (!adc_rd_n) begin hb_prev = hb_last; hb_last = adc_hben; rd_cnt++; end
                if (!adc_wr_n) begin
                    wl_prev = wl_last; wl_last = {adc_bus_oe, adc_hben, adc_bus_out}; wr_cnt++;
                end
            end
            if (adc_cs_n && !p_cs)
                chk(cs_len == STB_CYC, "R4 strobe width", cs_len, STB_CYC);
            if (!adc_convst_n && p_cv)
                chk(q_cnt >= QUIET_CYC, "R11 quiet before start", q_cnt, QUIET_CYC);
            if (adc_convst_n && !p_cv)
                chk(cv_len == CNV_CYC, "R3 start pulse width", cv_len, CNV_CYC);
            cs_len = adc_cs_n ? 0 : cs_len + 1;
            cv_len = adc_convst_n ? 0 : cv_len + 1;
            if (!adc_cs_n) begin
                gap_cnt = 0;
                if (!adc_rd_n) q_cnt = 0;
            end else begin
                gap_cnt++; q_cnt++;
            end
            p_cs = adc_cs_n; p_cv = adc_convst_n; p_rd = adc_rd_n;
        end
    end

    task automatic send(input logic wr, input logic [11:0] w, input logic bm, input logic tw);
        for (int i = 0; i < 400 && !cmd_ready; i++) @(negedge clk);
        tb_byte = bm; cmd_write = wr; cmd_wdata = w; cfg_byte_mode = bm; cfg_twos = tw;
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        chk(!cmd_ready, "R2 ready drops after accept", cmd_ready, 0);
    endtask

    task automatic wait_result();
        for (int i = 0; i < 400 && !res_valid && !conv_err; i++) @(negedge clk);
    endtask

    task automatic judge(input logic bm, input logic tw, input logic [11:0] d,
                         input logic [2:0] ch);
        logic [9:0] d10;
        d10 = d[11:2];
        chk(res_valid, "R3 result after busy falls", res_valid, 1);
        chk(adc_cs_n, "R9 valid after strobe release", adc_cs_n, 1);
        if (bm) chk(res_data == d, "R6 byte-mode data", res_data, d);
        else    chk(res_data == d, "R5 word-mode data", res_data, d);
        chk(res_chan == (bm ? ch : 3'd0), "R6 channel id", res_chan, bm ? ch : 3'd0);
        chk(res_value == {tw & d[11], d}, "R8 coded value", res_value, {tw & d[11], d});
        chk(w_valid && w_data == d10, "R7 10-bit data", w_data, d10);
        chk(w_value == {tw & d10[9], d10}, "R7 R8 10-bit value", w_value, {tw & d10[9], d10});
    endtask

    task automatic conv_chk(input logic bm, input logic tw, input logic [11:0] d,
                            input logic [2:0] ch, input int len);
        int rd0;
        rsp_data = d; rsp_chan = ch; conv_len = len;
        rd0 = rd_cnt;
        send(1'b0, 12'h000, bm, tw);
        wait_result();
        judge(bm, tw, d, ch);
        chk(rd_cnt - rd0 == (bm ? 2 : 1), "R4 read strobe count", rd_cnt - rd0, bm ? 2 : 1);
        if (bm) chk(hb_prev == 0 && hb_last == 1, "R4 byte order", {hb_prev, hb_last}, 2'b01);
        else    chk(hb_last == 0, "R4 word mode hben", hb_last, 0);
        @(negedge clk);
        chk(!res_valid, "R9 single-cycle valid", res_valid, 0);
    endtask

    task automatic wr_chk(input logic bm, input logic [11:0] w);
        int wr0, rd0, v0;
        wr0 = wr_cnt; rd0 = rd_cnt; v0 = val_cnt;
        send(1'b1, w, bm, 1'b0);
        for (int i = 0; i < 400 && !cmd_ready; i++) @(negedge clk);
        chk(wr_cnt - wr0 == (bm ? 2 : 1), "R10 write strobe count", wr_cnt - wr0, bm ? 2 : 1);
        chk(rd_cnt == rd0 && val_cnt == v0, "R10 no read or valid on write",
            {rd_cnt - rd0, val_cnt - v0}, 0);
        if (bm) begin
            chk(wl_prev == {2'b10, 4'h0, w[7:0]}, "R10 low byte write", wl_prev, {2'b10, 4'h0, w[7:0]});
            chk(wl_last == {2'b11, 8'h00, w[11:8]}, "R10 high byte write", wl_last, {2'b11, 8'h00, w[11:8]});
        end else begin
            chk(wl_last == {2'b10, w}, "R10 word write", wl_last, {2'b10, w});
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int rd0, v0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(adc_cs_n && adc_rd_n && adc_wr_n && adc_convst_n && !adc_bus_oe && !res_valid,
            "R1 strobes idle in reset", {adc_cs_n, adc_rd_n, adc_wr_n, adc_convst_n}, 4'hF);
        rst = 0;
        @(negedge clk);
        chk(cmd_ready && adc_cs_n && adc_convst_n && !res_valid, "R1 idle after reset",
            {cmd_ready, res_valid}, 2'b10);

        // Directed corners
        conv_chk(0, 0, 12'hABC, 3'd0, 12);
        conv_chk(1, 1, 12'h800, 3'd7, 14);
        conv_chk(1, 1, 12'h7FF, 3'd5, 10);
        conv_chk(0, 1, 12'hFFF, 3'd2, 16);
        conv_chk(1, 0, 12'h003, 3'd3, 13);
        wr_chk(0, 12'h5A3);
        wr_chk(1, 12'hC69);

        // Result and next acceptance in the same cycle
        rsp_data = 12'h321; rsp_chan = 3'd6; conv_len = 11;
        send(1'b0, 12'h000, 1'b1, 1'b0);
        wait_result();
        judge(1, 0, 12'h321, 3'd6);
        chk(cmd_ready, "R2 ready in valid cycle", cmd_ready, 1);
        rsp_data = 12'h9E7; rsp_chan = 3'd1;
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        wait_result();
        judge(1, 0, 12'h9E7, 3'd1);
        @(negedge clk);

        // Converter never finishes
        hang = 1; rd0 = rd_cnt; v0 = val_cnt;
        send(1'b0, 12'h000, 1'b0, 1'b0);
        wait_result();
        chk(conv_err, "R12 timeout flagged", conv_err, 1);
        chk(cmd_ready, "R12 idle after timeout", cmd_ready, 1);
        @(negedge clk);
        chk(!conv_err, "R12 error is a pulse", conv_err, 0);
        chk(rd_cnt == rd0 && val_cnt == v0, "R12 no read after timeout", rd_cnt - rd0, 0);
        hang = 0;
        repeat (4) @(negedge clk);

        // Reset in the middle of a conversion
        rsp_data = 12'h111; conv_len = 30;
        send(1'b0, 12'h000, 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk(adc_cs_n && adc_rd_n && adc_wr_n && adc_convst_n && cmd_ready,
            "R1 reset mid-conversion", {adc_cs_n, adc_convst_n, cmd_ready}, 3'b111);
        @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic        bm, tw;
            logic [11:0] d;
            logic [2:0]  ch;
            bm = 1'($urandom_range(0, 1));
            tw = 1'($urandom_range(0, 1));
            d  = 12'($urandom_range(0, 4095));
            ch = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) wr_chk(bm, d);
            else conv_chk(bm, tw, d, ch, $urandom_range(8, 25));
        end

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule